// File: doc/BRIEF.md
# Multi-page-size coalescing translation buffer

This block is a fully associative, single-level data translation buffer shared by two hardware threads. A lookup presents a thread number and a virtual address. One clock later the block returns a hit flag, a parity-error flag and the physical address. Every entry records its own page size: 4 KiB, 16 KiB, 2 MiB or 1 GiB. The tag compare ignores the page-offset bits that belong to that size. A 16 KiB entry is a coalesced group of four 4 KiB pages that are consecutive and 16 KiB aligned in both address spaces. A 4 MiB translation never occupies a single entry; the block installs it as two 2 MiB entries, one for the lower half and one for the upper half.

An external walker installs translations through the fill port. A fill first removes every entry of the same thread that overlaps the new range, so a lookup can match at most one entry. It then writes the new entry into a victim slot. The victim is the lowest-numbered invalid entry if one exists; otherwise a tree pseudo-LRU picks it. Both threads draw from one shared pool, so one thread's fills may evict the other thread's entries. Three maintenance requests are available: invalidate one address for one thread, flush one thread, and flush everything. Each takes a single cycle. Every entry carries a parity bit, and an error-injection input on the fill port can store a deliberately wrong parity bit.

A state machine sequences the work. `ST_READY` accepts maintenance, fills and lookups. `ST_READY -> ST_CLEAR` is taken on an accepted fill. `ST_CLEAR -> ST_WRITE` is always taken after the overlap purge. `ST_WRITE -> ST_WRITE_HI` is taken for a 4 MiB fill, and `ST_WRITE -> ST_READY` is taken otherwise. `ST_WRITE_HI -> ST_READY` writes the upper half. `ST_READY -> ST_SCRUB` is taken when an accepted lookup matched an entry with bad parity. `ST_SCRUB -> ST_READY` is taken after that entry is cleared. Maintenance requests keep the machine in `ST_READY`.

Top module: `xlat_buf`

## Requirements
- R1: After reset every entry is invalid, `lk_ready`, `fill_ready` and `maint_ready` are high, and `rsp_valid` is low.
- R2: A lookup accepted on a clock edge (`lk_valid && lk_ready`) produces `rsp_valid` for exactly the following cycle. On a miss, `rsp_hit` is 0 and `rsp_pa` is 0.
- R3: `fill_size` code 0 installs a 4 KiB page, code 2 a 2 MiB page and code 4 a 1 GiB page. Codes 5 to 7 are treated as 4 KiB. On a hit, `rsp_pa` takes its page-frame bits above the page size from the entry and its offset bits below the page size from the lookup address.
- R4: `fill_size` code 1 with `fill_contig` high installs one 16 KiB entry that translates all four 4 KiB pages of the aligned group.
- R5: `fill_size` code 1 with `fill_contig` low installs only the addressed 4 KiB page; neighbouring pages of the group miss.
- R6: `fill_size` code 3 (4 MiB) installs two 2 MiB entries. The upper half uses the address with page-number bit 9 set, and both halves translate.
- R7: A hit needs the thread number of the lookup to equal the entry's thread number.
- R8: A fill first invalidates every entry of the same thread whose range overlaps the new range, and only then writes, so no lookup ever matches two entries.
- R9: The victim is the lowest-numbered invalid entry if one exists. Otherwise it is chosen by a binary tree pseudo-LRU that is updated on every good lookup hit and on every fill write.
- R10: A lookup that matches an entry with a parity mismatch responds with `rsp_hit` = 0 and `rsp_perr` = 1. That entry is invalidated in the next cycle, and later lookups of the address miss with `rsp_perr` = 0.
- R11: In one cycle, flush-all clears every entry, flush-thread clears every entry of one thread, and invalidate-address clears the entry of that thread covering the address. When more than one is raised, flush-all wins over flush-thread, which wins over invalidate-address.
- R12: `lk_ready` is low while any maintenance request is raised, while `fill_valid` is high, and in every state other than `ST_READY`. A fill therefore wins over a lookup raised in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | Lookup can be accepted this cycle |
| lk_tid | input | 1 | Thread of the lookup |
| lk_va | input | 57 | Virtual address of the lookup |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Lookup hit a good entry |
| rsp_perr | output | 1 | Lookup matched an entry with bad parity |
| rsp_pa | output | 52 | Translated physical address |
| fill_valid | input | 1 | Fill request |
| fill_ready | output | 1 | Fill can be accepted this cycle |
| fill_tid | input | 1 | Thread of the new translation |
| fill_vpn | input | 45 | Virtual page number (4 KiB units) |
| fill_pfn | input | 40 | Physical frame number (4 KiB units) |
| fill_size | input | 3 | Page size code (see R3 to R6) |
| fill_contig | input | 1 | Walker confirms four contiguous aligned small pages |
| fill_par_flip | input | 1 | Store inverted parity (error injection) |
| inv_valid | input | 1 | Invalidate one address |
| inv_tid | input | 1 | Thread for address invalidation |
| inv_vpn | input | 45 | Page number for address invalidation |
| tflush_valid | input | 1 | Flush one thread |
| tflush_tid | input | 1 | Thread to flush |
| aflush_valid | input | 1 | Flush every entry |
| maint_ready | output | 1 | Maintenance requests are honoured this cycle |

## Verification
The checks take for granted that the walker supplies fill page numbers aligned to the page size and raises `fill_contig` only for a real contiguous group. They also assume that maintenance requests are raised only while `maint_ready` is high. The bench keeps to this by installing only aligned translations and by driving each request for one cycle from an idle machine. Under these conditions the single-match property and the flush-all property hold.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    parameter int VA_W     = 57;
    parameter int PA_W     = 52;
    parameter int TID_W    = 1;
    parameter int PG_SHIFT = 12;
    parameter int SH_16K   = 2;
    parameter int SH_2M    = 9;
    parameter int SH_4M    = 10;
    parameter int SH_1G    = 18;

    localparam int VPN_W = VA_W - PG_SHIFT;
    localparam int PFN_W = PA_W - PG_SHIFT;

    typedef enum logic [1:0] {PG_4K, PG_16K, PG_2M, PG_1G} pgsz_e;

    typedef enum logic [2:0] {
        FS_4K = 3'd0, FS_16K = 3'd1, FS_2M = 3'd2, FS_4M = 3'd3, FS_1G = 3'd4
    } fill_code_e;

    typedef struct packed {
        logic             valid;
        logic [TID_W-1:0] tid;
        pgsz_e            size;
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
        logic             par;
    } ent_t;

    function automatic logic [VPN_W-1:0] keep_above(input int unsigned n);
        return {VPN_W{1'b1}} << n;
    endfunction

    function automatic logic [VPN_W-1:0] size_mask(input pgsz_e s);
        unique case (s)
            PG_4K:  return keep_above(0);
            PG_16K: return keep_above(SH_16K);
            PG_2M:  return keep_above(SH_2M);
            PG_1G:  return keep_above(SH_1G);
        endcase
    endfunction

    function automatic logic ent_par(input logic [TID_W-1:0] tid, input pgsz_e s,
                                     input logic [VPN_W-1:0] vpn,
                                     input logic [PFN_W-1:0] pfn);
        return ^{tid, s, vpn, pfn};
    endfunction
endpackage

// File: rtl/xlat_match.sv
module xlat_match
    import xlat_pkg::*;
#(
    parameter int N = 72
) (
    input  ent_t             ents [N],
    input  logic [TID_W-1:0] key_tid,
    input  logic [VPN_W-1:0] key_vpn,
    input  logic [VPN_W-1:0] key_mask,
    output logic [N-1:0]     hit_vec,
    output logic [N-1:0]     bad_vec
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        logic [VPN_W-1:0] emask;
        logic             par_ok;
        assign emask  = size_mask(ents[g].size);
        assign par_ok = ent_par(ents[g].tid, ents[g].size, ents[g].vpn, ents[g].pfn)
                        == ents[g].par;
        assign hit_vec[g] = ents[g].valid && (ents[g].tid == key_tid) &&
                            (((ents[g].vpn ^ key_vpn) & emask & key_mask) == '0);
        assign bad_vec[g] = hit_vec[g] && !par_ok;
    end
endmodule

// File: rtl/xlat_repl.sv
module xlat_repl #(
    parameter int N     = 72,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic [N-1:0]     valid_vec,
    output logic [IDX_W-1:0] victim
);
    localparam int LVL    = IDX_W;
    localparam int LEAVES = 1 << LVL;

    logic [LEAVES-1:1] tree;
    logic [IDX_W-1:0]  free_idx;
    logic              any_free;
    logic [IDX_W-1:0]  lru_idx;

    always_comb begin
        free_idx = '0;
        any_free = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
        end
    end

    always_comb begin
        int node;
        int right_leaf;
        node = 1;
        for (int lvl = 0; lvl < LVL; lvl++) begin
            right_leaf = ((2 * node + 1) << (LVL - lvl - 1)) - LEAVES;
            if (tree[LVL'(node)] && right_leaf < N) node = 2 * node + 1;
            else                                    node = 2 * node;
        end
        lru_idx = IDX_W'(node - LEAVES);
    end

    assign victim = any_free ? free_idx : lru_idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tree <= '0;
        end else if (touch_en) begin
            for (int lvl = 0; lvl < LVL; lvl++) begin
                tree[LVL'((int'(touch_idx) + LEAVES) >> (LVL - lvl))] <=
                    ~touch_idx[LVL-1-lvl];
            end
        end
    end
endmodule

// File: rtl/xlat_buf.sv
module xlat_buf
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 72
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    output logic             lk_ready,
    input  logic [TID_W-1:0] lk_tid,
    input  logic [VA_W-1:0]  lk_va,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_perr,
    output logic [PA_W-1:0]  rsp_pa,
    input  logic             fill_valid,
    output logic             fill_ready,
    input  logic [TID_W-1:0] fill_tid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic [2:0]       fill_size,
    input  logic             fill_contig,
    input  logic             fill_par_flip,
    input  logic             inv_valid,
    input  logic [TID_W-1:0] inv_tid,
    input  logic [VPN_W-1:0] inv_vpn,
    input  logic             tflush_valid,
    input  logic [TID_W-1:0] tflush_tid,
    input  logic             aflush_valid,
    output logic             maint_ready
);
    localparam int IDX_W = $clog2(ENTRIES);

    typedef enum logic [2:0] {
        ST_READY, ST_CLEAR, ST_WRITE, ST_WRITE_HI, ST_SCRUB
    } state_e;

    state_e state, nxt;

    ent_t               ents [ENTRIES];
    logic [ENTRIES-1:0] valid_vec;
    logic [ENTRIES-1:0] hit_vec;
    logic [ENTRIES-1:0] bad_vec;

    logic             maint_req, maint_go, fill_go, lk_go;
    logic [TID_W-1:0] key_tid;
    logic [VPN_W-1:0] key_vpn, key_mask;

    logic [TID_W-1:0] f_tid;
    logic [VPN_W-1:0] f_vpn, f_clr_mask;
    logic [PFN_W-1:0] f_pfn;
    pgsz_e            f_size;
    logic             f_four, f_flip;

    pgsz_e            dec_size;
    logic             dec_four;
    logic [VPN_W-1:0] dec_clr;

    logic [IDX_W-1:0] hit_idx, bad_idx, s_idx, victim;
    logic [PFN_W-1:0] hit_pfn, pa_pfn;
    logic [VPN_W-1:0] hit_msk, lk_vpn;
    logic             any_hit, any_bad;
    logic             touch_en;
    logic [IDX_W-1:0] touch_idx;
    logic [VPN_W-1:0] hi_vpn;
    logic [PFN_W-1:0] hi_pfn;

    assign lk_vpn = lk_va[VA_W-1:PG_SHIFT];
    assign hi_vpn = f_vpn | (VPN_W'(1) << SH_2M);
    assign hi_pfn = f_pfn | (PFN_W'(1) << SH_2M);

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_READY;
        else        state <= nxt;
    end

    // ---------------- next state ----------------
    always_comb begin
        nxt = state;
        unique case (state)
            ST_READY: begin
                if (maint_go)                nxt = ST_READY;
                else if (fill_go)            nxt = ST_CLEAR;
                else if (lk_go && any_bad)   nxt = ST_SCRUB;
            end
            ST_CLEAR:    nxt = ST_WRITE;
            ST_WRITE:    nxt = f_four ? ST_WRITE_HI : ST_READY;
            ST_WRITE_HI: nxt = ST_READY;
            ST_SCRUB:    nxt = ST_READY;
        endcase
    end

    // ---------------- handshake outputs ----------------
    always_comb begin
        maint_req   = inv_valid || tflush_valid || aflush_valid;
        maint_ready = (state == ST_READY);
        fill_ready  = (state == ST_READY) && !maint_req;
        lk_ready    = (state == ST_READY) && !maint_req && !fill_valid;
        maint_go    = maint_ready && maint_req;
        fill_go     = fill_valid && fill_ready;
        lk_go       = lk_valid && lk_ready;
    end

    // ---------------- fill size decode ----------------
    always_comb begin
        dec_four = 1'b0;
        dec_size = PG_4K;
        case (fill_size)
            FS_16K:  dec_size = fill_contig ? PG_16K : PG_4K;
            FS_2M:   dec_size = PG_2M;
            FS_4M:   begin dec_size = PG_2M; dec_four = 1'b1; end
            FS_1G:   dec_size = PG_1G;
            default: dec_size = PG_4K;
        endcase
        dec_clr = dec_four ? keep_above(SH_4M) : size_mask(dec_size);
    end

    // ---------------- compare key select ----------------
    always_comb begin
        if (state == ST_CLEAR) begin
            key_tid = f_tid; key_vpn = f_vpn; key_mask = f_clr_mask;
        end else if (inv_valid) begin
            key_tid = inv_tid; key_vpn = inv_vpn; key_mask = '1;
        end else begin
            key_tid = lk_tid; key_vpn = lk_vpn; key_mask = '1;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_valid
        assign valid_vec[g] = ents[g].valid;
    end

    xlat_match #(.N(ENTRIES)) u_match (
        .ents     (ents),
        .key_tid  (key_tid),
        .key_vpn  (key_vpn),
        .key_mask (key_mask),
        .hit_vec  (hit_vec),
        .bad_vec  (bad_vec)
    );

    // ---------------- hit selection and address merge ----------------
    always_comb begin
        hit_idx = '0;
        bad_idx = '0;
        hit_pfn = '0;
        hit_msk = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) begin
                hit_idx = IDX_W'(i);
                hit_pfn = hit_pfn | ents[i].pfn;
                hit_msk = hit_msk | size_mask(ents[i].size);
            end
            if (bad_vec[i]) bad_idx = IDX_W'(i);
        end
        any_hit = |hit_vec;
        any_bad = |bad_vec;
        pa_pfn  = (hit_pfn & hit_msk[PFN_W-1:0]) | (lk_vpn[PFN_W-1:0] & ~hit_msk[PFN_W-1:0]);
    end

    // ---------------- replacement ----------------
    always_comb begin
        touch_en  = (lk_go && any_hit && !any_bad) ||
                    (state == ST_WRITE) || (state == ST_WRITE_HI);
        touch_idx = (state == ST_READY) ? hit_idx : victim;
    end

    xlat_repl #(.N(ENTRIES), .IDX_W(IDX_W)) u_repl (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch_en  (touch_en),
        .touch_idx (touch_idx),
        .valid_vec (valid_vec),
        .victim    (victim)
    );

    // ---------------- fill request latch and scrub index ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_tid <= '0; f_vpn <= '0; f_pfn <= '0; f_size <= PG_4K;
            f_four <= 1'b0; f_flip <= 1'b0; f_clr_mask <= '0; s_idx <= '0;
        end else begin
            if (fill_go) begin
                f_tid      <= fill_tid;
                f_vpn      <= dec_four ? (fill_vpn & ~(VPN_W'(1) << SH_2M)) : fill_vpn;
                f_pfn      <= dec_four ? (fill_pfn & ~(PFN_W'(1) << SH_2M)) : fill_pfn;
                f_size     <= dec_size;
                f_four     <= dec_four;
                f_flip     <= fill_par_flip;
                f_clr_mask <= dec_clr;
            end
            if (lk_go && any_bad) s_idx <= bad_idx;
        end
    end

    // ---------------- entry array ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ents[i] <= '0;
        end else begin
            unique case (state)
                ST_READY: begin
                    if (aflush_valid) begin
                        for (int i = 0; i < ENTRIES; i++) ents[i].valid <= 1'b0;
                    end else if (tflush_valid) begin
                        for (int i = 0; i < ENTRIES; i++)
                            if (ents[i].tid == tflush_tid) ents[i].valid <= 1'b0;
                    end else if (inv_valid) begin
                        for (int i = 0; i < ENTRIES; i++)
                            if (hit_vec[i]) ents[i].valid <= 1'b0;
                    end
                end
                ST_CLEAR: begin
                    for (int i = 0; i < ENTRIES; i++)
                        if (hit_vec[i]) ents[i].valid <= 1'b0;
                end
                ST_WRITE: begin
                    ents[victim] <= '{valid: 1'b1, tid: f_tid, size: f_size,
                                      vpn: f_vpn, pfn: f_pfn,
                                      par: ent_par(f_tid, f_size, f_vpn, f_pfn) ^ f_flip};
                end
                ST_WRITE_HI: begin
                    ents[victim] <= '{valid: 1'b1, tid: f_tid, size: f_size,
                                      vpn: hi_vpn, pfn: hi_pfn,
                                      par: ent_par(f_tid, f_size, hi_vpn, hi_pfn) ^ f_flip};
                end
                ST_SCRUB: ents[s_idx].valid <= 1'b0;
            endcase
        end
    end

    // ---------------- response register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0; rsp_hit <= 1'b0; rsp_perr <= 1'b0; rsp_pa <= '0;
        end else begin
            rsp_valid <= lk_go;
            if (lk_go) begin
                rsp_hit  <= any_hit && !any_bad;
                rsp_perr <= any_bad;
                rsp_pa   <= (any_hit && !any_bad) ? {pa_pfn, lk_va[PG_SHIFT-1:0]} : '0;
            end
        end
    end
endmodule

// File: rtl/xlat_buf_chk.sv
module xlat_buf_chk #(
    parameter int N = 72
) (
    input logic         clk,
    input logic         rst_n,
    input logic         lk_valid,
    input logic         lk_ready,
    input logic         rsp_valid,
    input logic         rsp_hit,
    input logic         rsp_perr,
    input logic         inv_valid,
    input logic         tflush_valid,
    input logic         aflush_valid,
    input logic         maint_ready,
    input logic [N-1:0] hit_vec,
    input logic [N-1:0] valid_vec
);
    p_rsp_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ready) |=> rsp_valid);

    p_rsp_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_valid && lk_ready) |=> !rsp_valid);

    p_single_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ready) |-> $onehot0(hit_vec));

    p_perr_is_miss_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_perr) |-> (!rsp_hit && !lk_ready));

    p_maint_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid || tflush_valid || aflush_valid) |-> !lk_ready);

    p_flush_all_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (aflush_valid && maint_ready) |=> (valid_vec == '0));
endmodule

bind xlat_buf xlat_buf_chk #(.N(ENTRIES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_valid     (lk_valid),
    .lk_ready     (lk_ready),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_perr     (rsp_perr),
    .inv_valid    (inv_valid),
    .tflush_valid (tflush_valid),
    .aflush_valid (aflush_valid),
    .maint_ready  (maint_ready),
    .hit_vec      (hit_vec),
    .valid_vec    (valid_vec)
);

// File: tb/xlat_buf_test.sv
module xlat_buf_test;
    import xlat_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic             lk_valid = 0, lk_ready;
    logic [TID_W-1:0] lk_tid = 0;
    logic [VA_W-1:0]  lk_va = 0;
    logic             rsp_valid, rsp_hit, rsp_perr;
    logic [PA_W-1:0]  rsp_pa;
    logic             fill_valid = 0, fill_ready;
    logic [TID_W-1:0] fill_tid = 0;
    logic [VPN_W-1:0] fill_vpn = 0;
    logic [PFN_W-1:0] fill_pfn = 0;
    logic [2:0]       fill_size = 0;
    logic             fill_contig = 0, fill_par_flip = 0;
    logic             inv_valid = 0;
    logic [TID_W-1:0] inv_tid = 0;
    logic [VPN_W-1:0] inv_vpn = 0;
    logic             tflush_valid = 0;
    logic [TID_W-1:0] tflush_tid = 0;
    logic             aflush_valid = 0, maint_ready;

    xlat_buf #(.ENTRIES(4)) uut (.*);

    int errors = 0, checks = 0, cycles = 0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    logic r_hit, r_perr;
    logic [PA_W-1:0] r_pa;

    task automatic lookup(input logic [TID_W-1:0] tid, input logic [63:0] va);
        @(negedge clk);
        lk_valid = 1; lk_tid = tid; lk_va = VA_W'(va);
        #1;
        while (!lk_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        lk_valid = 0;
        check("R2 rsp_valid", 64'(rsp_valid), 64'd1);
        r_hit = rsp_hit; r_perr = rsp_perr; r_pa = rsp_pa;
    endtask

    task automatic expect_hit(input string req, input logic [TID_W-1:0] tid,
                              input logic [63:0] vbase, input logic [63:0] pbase,
                              input logic [63:0] off);
        lookup(tid, vbase + off);
        check({req, " hit"}, 64'(r_hit), 64'd1);
        check({req, " pa"}, 64'(r_pa), 64'(PA_W'(pbase + off)));
    endtask

    task automatic expect_miss(input string req, input logic [TID_W-1:0] tid,
                               input logic [63:0] va);
        lookup(tid, va);
        check({req, " miss"}, 64'(r_hit), 64'd0);
        check({req, " miss pa"}, 64'(r_pa), 64'd0);
    endtask

    task automatic fill(input logic [TID_W-1:0] tid, input logic [63:0] va,
                        input logic [63:0] pa, input logic [2:0] code,
                        input logic contig, input logic flip);
        @(negedge clk);
        fill_valid = 1; fill_tid = tid; fill_vpn = VPN_W'(va >> 12);
        fill_pfn = PFN_W'(pa >> 12); fill_size = code;
        fill_contig = contig; fill_par_flip = flip;
        #1;
        check("R12 fill beats lookup", 64'(lk_ready), 64'd0);
        while (!fill_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        fill_valid = 0; fill_par_flip = 0;
        #1;
        check("R12 stall during fill", 64'(lk_ready), 64'd0);
        while (!fill_ready) begin @(negedge clk); #1; end
    endtask

    localparam logic [63:0] VA_A = 64'h12_3456_7000, PA_A = 64'h9_8765_4000;
    localparam logic [63:0] VA_B = 64'h22_0000_8000, PA_B = 64'h3_0000_C000;
    localparam logic [63:0] VA_C = 64'h44_0001_0000, PA_C = 64'h5_0002_0000;
    localparam logic [63:0] VA_D = 64'h66_0020_0000, PA_D = 64'h7_0040_0000;
    localparam logic [63:0] VA_E = 64'h1_8000_0000,  PA_E = 64'h2_0000_0000;
    localparam logic [63:0] VA_N = 64'h1_8000_2000,  PA_N = 64'hA_BCDE_F000;
    localparam logic [63:0] VA_F = 64'h99_0040_0000, PA_F = 64'h8_00C0_0000;
    localparam logic [63:0] VA_G = 64'h55_5555_5000, PA_G = 64'h1_1111_1000;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        check("R1 lk_ready", 64'(lk_ready), 64'd1);
        check("R1 fill_ready", 64'(fill_ready), 64'd1);
        check("R1 maint_ready", 64'(maint_ready), 64'd1);
        check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
        expect_miss("R1 empty", 0, VA_A);
        @(negedge clk);
        check("R2 single-cycle response", 64'(rsp_valid), 64'd0);

        // R3 4 KiB page, R7 thread match
        fill(0, VA_A, PA_A, 3'd0, 0, 0);                      // entry 0
        expect_hit("R3 4K", 0, VA_A, PA_A, 64'hABC);
        expect_miss("R7 other thread", 1, VA_A + 64'hABC);
        expect_miss("R3 next page", 0, VA_A + 64'h1000);

        // R4 coalesced 16 KiB sweep
        fill(0, VA_B, PA_B, 3'd1, 1, 0);                      // entry 1
        for (int k = 0; k < 4; k++)
            expect_hit("R4 16K", 0, VA_B, PA_B, 64'(k) * 64'h1000 + 64'h123);

        // R5 16 KiB without contiguity
        fill(0, VA_C, PA_C, 3'd1, 0, 0);                      // entry 2
        expect_hit("R5 base page", 0, VA_C, PA_C, 64'hFFF);
        expect_miss("R5 neighbour", 0, VA_C + 64'h1000);

        // R3 2 MiB page for thread 1
        fill(1, VA_D, PA_D, 3'd2, 0, 0);                      // entry 3
        expect_hit("R3 2M", 1, VA_D, PA_D, 64'h1_2345);

        // R9 array full: pseudo-LRU victim is entry 0 (A)
        fill(0, VA_E, PA_E, 3'd4, 0, 0);
        expect_miss("R9 plru evicts A", 0, VA_A);
        expect_hit("R3 1G", 0, VA_E, PA_E, 64'h1234_5678);
        expect_hit("R9 B kept", 0, VA_B, PA_B, 64'h10);

        // R8 overlap purge: 4 KiB inside the 1 GiB page
        fill(0, VA_N, PA_N, 3'd0, 0, 0);
        expect_miss("R8 old 1G gone", 0, VA_E + 64'h1234_5678);
        expect_hit("R8 new 4K", 0, VA_N, PA_N, 64'hABC);

        // R6 4 MiB as two halves; R9 victims 2 then... (C then B evicted)
        fill(1, VA_F, PA_F, 3'd3, 0, 0);
        expect_hit("R6 low half", 1, VA_F, PA_F, 64'h1_2345);
        expect_hit("R6 high half", 1, VA_F, PA_F, 64'h20_0000 + 64'h6_789A);
        expect_miss("R9 C evicted", 0, VA_C);
        expect_miss("R9 B evicted", 0, VA_B);
        expect_hit("R9 D kept", 1, VA_D, PA_D, 64'h5);

        // R11 invalidate one address
        @(negedge clk);
        inv_valid = 1; inv_tid = 1; inv_vpn = VPN_W'((VA_F + 64'h20_0005) >> 12);
        #1; check("R12 stall on invalidate", 64'(lk_ready), 64'd0);
        @(posedge clk); @(negedge clk); inv_valid = 0;
        expect_miss("R11 inv high half", 1, VA_F + 64'h20_0005);
        expect_hit("R11 low half kept", 1, VA_F, PA_F, 64'h10);

        // R11 flush one thread
        @(negedge clk);
        tflush_valid = 1; tflush_tid = 1;
        #1; check("R12 stall on thread flush", 64'(lk_ready), 64'd0);
        @(posedge clk); @(negedge clk); tflush_valid = 0;
        expect_miss("R11 tflush F", 1, VA_F + 64'h10);
        expect_miss("R11 tflush D", 1, VA_D);
        expect_hit("R11 other thread kept", 0, VA_N, PA_N, 64'h1);

        // R10 parity error
        fill(0, VA_G, PA_G, 3'd0, 0, 1);
        lookup(0, VA_G + 64'h44);
        check("R10 perr", 64'(r_perr), 64'd1);
        check("R10 no hit", 64'(r_hit), 64'd0);
        check("R10 scrub stall", 64'(lk_ready), 64'd0);
        lookup(0, VA_G + 64'h44);
        check("R10 scrubbed perr", 64'(r_perr), 64'd0);
        check("R10 scrubbed hit", 64'(r_hit), 64'd0);

        // R11 priority: flush-all with thread flush of the other thread
        @(negedge clk);
        aflush_valid = 1; tflush_valid = 1; tflush_tid = 1;
        #1; check("R12 stall on flush all", 64'(lk_ready), 64'd0);
        @(posedge clk); @(negedge clk); aflush_valid = 0; tflush_valid = 0;
        expect_miss("R11 flush all", 0, VA_N + 64'h1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule